// File: doc/BRIEF.md
# Rectangle Fill and Copy Engine

This block carries out two-dimensional drawing operations on a linear framebuffer that it reaches through a byte-wide memory port. A command supplies an operation (solid fill or rectangle copy), destination and source corners, a size in pixels and a 32-bit colour. Pixel size is selectable from one to four bytes. Every byte address is derived from the screen width and the pixel size, so the framebuffer needs no row padding.

A copy picks its walking order from where the source and destination lie relative to each other. That way a move onto an overlapping area gives the same result as copying from a snapshot of the source. Each completed operation appends its destination rectangle to a circular dirty-rectangle queue. A flush request either throws the queue away, when the whole screen is already known to be stale, or streams the queued rectangles out one per cycle, each clipped to the visible screen.

Top module: `rfe_engine`

## Requirements
- R1: The byte address of pixel (x, y) is bypp*x + bypp*scr_w*y. A row of w pixels covers w*bypp consecutive bytes starting at the address of its first pixel.
- R2: A fill writes the colour bytes least significant first (byte k of a row, counted from 0, gets bits [8*(k mod bypp)+7 : 8*(k mod bypp)]), restarting at byte 0 of the colour on every row. It makes exactly w*bypp*h writes.
- R3: The memory left by a copy equals a copy taken from a snapshot of the source area, for any overlap. When the destination row is below the source row, rows go last to first. When both rows are equal and the destination column is to the right, bytes within a row go right to left.
- R4: A copy moves each byte with one read cycle (mem_re) followed by one write cycle (mem_we) of the same byte; read data is taken one cycle after mem_re. It makes exactly 2*w*bypp*h accesses, and a read and a write never share a cycle.
- R5: A command with zero width or zero height makes no memory access and still completes with done.
- R6: cmd_ready is high only while the engine is idle, and a command is taken when cmd_valid and cmd_ready are both high (cmd_op 0 = fill, 1 = copy). done is a one-cycle pulse in the cycle after the final write, and cmd_ready returns in the cycle after done.
- R7: Every finished command, including a zero-sized one, pushes its destination rectangle (dx, dy, w, h) into a queue of QDEPTH entries whose write index wraps modulo QDEPTH with no full check. QDEPTH pushes with no drain in between leave the queue looking empty.
- R8: A flush_req taken with full_inval high empties the queue in one cycle without producing any rectangle. A rectangle pushed in that same cycle stays in the queue.
- R9: A flush_req taken with full_inval low raises flush_busy and presents the queued rectangles oldest first, one per cycle with rect_valid, until the queue is empty. flush_req is ignored while flush_busy is high.
- R10: Each presented rectangle is clipped: x becomes min(x, scr_w), and if x+w exceeds scr_w then w becomes scr_w minus the new x. The same rule applies to y and h with scr_h.
- R11: After reset the engine is idle (cmd_ready high) with done, mem_re, mem_we, flush_busy and rect_valid low and the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scr_w | input | CW | Screen width in pixels |
| scr_h | input | CW | Screen height in pixels |
| bypp | input | 3 | Bytes per pixel, 1 to 4, sampled when a command is taken |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle and able to take a command |
| cmd_op | input | 1 | 0 = fill, 1 = copy |
| cmd_sx | input | CW | Copy source x |
| cmd_sy | input | CW | Copy source y |
| cmd_dx | input | CW | Destination x |
| cmd_dy | input | CW | Destination y |
| cmd_w | input | CW | Width in pixels |
| cmd_h | input | CW | Height in pixels |
| cmd_color | input | 32 | Fill colour |
| done | output | 1 | One-cycle completion pulse |
| mem_re | output | 1 | Byte read strobe |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid one cycle after mem_re |
| flush_req | input | 1 | Request to drain or discard the dirty queue |
| full_inval | input | 1 | Whole screen stale: discard instead of drain |
| flush_busy | output | 1 | Drain in progress |
| rect_valid | output | 1 | A clipped dirty rectangle is presented |
| rect_x | output | CW | Clipped rectangle x |
| rect_y | output | CW | Clipped rectangle y |
| rect_w | output | CW | Clipped rectangle width |
| rect_h | output | CW | Clipped rectangle height |

## Verification
The completion of a command, which pushes its rectangle, can share a clock edge with a flush that discards the queue. The bench provokes this by raising flush_req with full_inval while it sees done high, after two earlier rectangles were already queued. A following normal drain must yield exactly one rectangle, the one from the concurrent command, which shows that the discard removed only the older entries. A drain that overlaps a push is also judged by the oldest-first order of the rectangles that come out.

// File: rtl/rfe_pkg.sv
package rfe_pkg;

    typedef enum logic [0:0] {
        OP_FILL = 1'b0,
        OP_COPY = 1'b1
    } rfe_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2,
        ST_FIN  = 2'd3
    } rfe_st_e;

endpackage

// File: rtl/rfe_pix_addr.sv
// Linear byte address of a pixel: bypp*x + bypp*width*y.
module rfe_pix_addr #(
    parameter int CW = 12,
    parameter int AW = 24
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [2:0]    bypp,
    input  logic [CW-1:0] scr_w,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] pitch;

    always_comb begin
        pitch = AW'(bypp) * AW'(scr_w);
        addr  = AW'(bypp) * AW'(x) + pitch * AW'(y);
    end
endmodule

// File: rtl/rfe_clip.sv
// Clips a rectangle {h, w, y, x} to the screen, one axis per generate lane.
module rfe_clip #(
    parameter int CW = 12
) (
    input  logic [4*CW-1:0] rect_in,
    input  logic [CW-1:0]   scr_w,
    input  logic [CW-1:0]   scr_h,
    output logic [4*CW-1:0] rect_out
);
    for (genvar a = 0; a < 2; a++) begin : g_axis
        logic [CW-1:0] pos, len, lim, pos_c, len_c;
        logic [CW:0]   span;

        assign lim  = (a == 0) ? scr_w : scr_h;
        assign pos  = rect_in[a*CW +: CW];
        assign len  = rect_in[(a+2)*CW +: CW];
        assign span = {1'b0, pos} + {1'b0, len};

        always_comb begin
            pos_c = (pos > lim) ? lim : pos;
            len_c = (span > {1'b0, lim}) ? (lim - pos_c) : len;
        end

        assign rect_out[a*CW +: CW]     = pos_c;
        assign rect_out[(a+2)*CW +: CW] = len_c;
    end
endmodule

// File: rtl/rfe_dirty_q.sv
// Circular dirty-rectangle store; the write index wraps without a full check.
module rfe_dirty_q #(
    parameter int CW    = 12,
    parameter int DEPTH = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [4*CW-1:0] push_rect,
    input  logic            pop,
    input  logic            discard,
    output logic            empty,
    output logic [4*CW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int RW = 4*CW;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t          q, d;
    logic [RW-1:0] slots [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        d = q;
        if (push) d.wr = bump(q.wr);
        if (discard)  d.rd = q.wr;
        else if (pop) d.rd = bump(q.rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (push) slots[q.wr] <= push_rect;
    end

    assign empty = (q.wr == q.rd);
    assign head  = slots[q.rd];
endmodule

// File: rtl/rfe_engine.sv
module rfe_engine
    import rfe_pkg::*;
#(
    parameter int CW     = 12,
    parameter int AW     = 24,
    parameter int QDEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] scr_w,
    input  logic [CW-1:0] scr_h,
    input  logic [2:0]    bypp,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_op,
    input  logic [CW-1:0] cmd_sx,
    input  logic [CW-1:0] cmd_sy,
    input  logic [CW-1:0] cmd_dx,
    input  logic [CW-1:0] cmd_dy,
    input  logic [CW-1:0] cmd_w,
    input  logic [CW-1:0] cmd_h,
    input  logic [31:0]   cmd_color,
    output logic          done,
    output logic          mem_re,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          flush_req,
    input  logic          full_inval,
    output logic          flush_busy,
    output logic          rect_valid,
    output logic [CW-1:0] rect_x,
    output logic [CW-1:0] rect_y,
    output logic [CW-1:0] rect_w,
    output logic [CW-1:0] rect_h
);
    localparam int BW = CW + 2;   // bytes in one row: up to 4*w
    localparam int RW = 4*CW;

    typedef struct packed {
        rfe_st_e       st;
        rfe_op_e       op;
        logic [CW-1:0] sx, sy, dx, dy, w, h;
        logic [31:0]   color;
        logic [2:0]    bpp;
        logic [BW-1:0] wb;
        logic [CW-1:0] r;
        logic [BW-1:0] b;
        logic [1:0]    ph;
        logic          rev_r;
        logic          rev_c;
        logic          drain;
    } state_t;

    state_t q, d;

    // traversal position
    logic [CW-1:0] row_off, src_row, dst_row;
    logic [BW-1:0] col;
    logic [AW-1:0] src_base, dst_base;
    logic          last_b, last_r;

    // queue side
    logic          q_push, q_pop, q_discard, q_empty;
    logic [RW-1:0] q_head, q_clip;

    always_comb begin
        row_off = q.rev_r ? (q.h - CW'(1) - q.r) : q.r;
        src_row = q.sy + row_off;
        dst_row = q.dy + row_off;
        col     = q.rev_c ? (q.wb - BW'(1) - q.b) : q.b;
        last_b  = (q.b == q.wb - BW'(1));
        last_r  = (q.r == q.h - CW'(1));
    end

    rfe_pix_addr #(.CW(CW), .AW(AW)) u_src_addr (
        .x(q.sx), .y(src_row), .bypp(q.bpp), .scr_w(scr_w), .addr(src_base)
    );

    rfe_pix_addr #(.CW(CW), .AW(AW)) u_dst_addr (
        .x(q.dx), .y(dst_row), .bypp(q.bpp), .scr_w(scr_w), .addr(dst_base)
    );

    always_comb begin
        d         = q;
        cmd_ready = 1'b0;
        done      = 1'b0;
        mem_re    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        q_discard = 1'b0;
        rect_valid = 1'b0;

        unique case (q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    d.op    = rfe_op_e'(cmd_op);
                    d.sx    = cmd_sx;
                    d.sy    = cmd_sy;
                    d.dx    = cmd_dx;
                    d.dy    = cmd_dy;
                    d.w     = cmd_w;
                    d.h     = cmd_h;
                    d.color = cmd_color;
                    d.bpp   = bypp;
                    d.wb    = BW'(cmd_w) * BW'(bypp);
                    d.r     = '0;
                    d.b     = '0;
                    d.ph    = '0;
                    d.rev_r = cmd_op && (cmd_dy > cmd_sy);
                    d.rev_c = cmd_op && (cmd_dy == cmd_sy) && (cmd_dx > cmd_sx);
                    if (cmd_w == '0 || cmd_h == '0) d.st = ST_FIN;
                    else if (cmd_op)                d.st = ST_RD;
                    else                            d.st = ST_WR;
                end
            end
            ST_RD: begin
                mem_re   = 1'b1;
                mem_addr = src_base + AW'(col);
                d.st     = ST_WR;
            end
            ST_WR: begin
                mem_we    = 1'b1;
                mem_addr  = dst_base + AW'(col);
                mem_wdata = (q.op == OP_COPY) ? mem_rdata
                                              : 8'(q.color >> {q.ph, 3'b000});
                d.st      = (q.op == OP_COPY) ? ST_RD : ST_WR;
                if (last_b) begin
                    d.b  = '0;
                    d.ph = '0;
                    if (last_r) d.st = ST_FIN;
                    else        d.r  = q.r + CW'(1);
                end else begin
                    d.b  = q.b + BW'(1);
                    d.ph = (q.ph == 2'(q.bpp - 3'd1)) ? 2'd0 : q.ph + 2'd1;
                end
            end
            ST_FIN: begin
                done   = 1'b1;
                q_push = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase

        // dirty queue drain, independent of the drawing state machine
        if (!q.drain) begin
            if (flush_req) begin
                if (full_inval) q_discard = 1'b1;
                else            d.drain   = 1'b1;
            end
        end else if (q_empty) begin
            d.drain = 1'b0;
        end else begin
            rect_valid = 1'b1;
            q_pop      = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.op    <= OP_FILL;
        end else begin
            q <= d;
        end
    end

    rfe_dirty_q #(.CW(CW), .DEPTH(QDEPTH)) u_dirty (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_rect({q.h, q.w, q.dy, q.dx}),
        .pop(q_pop), .discard(q_discard),
        .empty(q_empty), .head(q_head)
    );

    rfe_clip #(.CW(CW)) u_clip (
        .rect_in(q_head), .scr_w(scr_w), .scr_h(scr_h), .rect_out(q_clip)
    );

    assign flush_busy = q.drain;
    assign rect_x = q_clip[0*CW +: CW];
    assign rect_y = q_clip[1*CW +: CW];
    assign rect_w = q_clip[2*CW +: CW];
    assign rect_h = q_clip[3*CW +: CW];
endmodule

// File: rtl/rfe_engine_chk.sv
module rfe_engine_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] scr_w,
    input logic [CW-1:0] scr_h,
    input logic          cmd_ready,
    input logic          done,
    input logic          mem_re,
    input logic          mem_we,
    input logic          flush_busy,
    input logic          rect_valid,
    input logic [CW-1:0] rect_x,
    input logic [CW-1:0] rect_y,
    input logic [CW-1:0] rect_w,
    input logic [CW-1:0] rect_h
);
    p_port_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> mem_we);

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!mem_re && !mem_we));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_to_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready);

    p_rect_in_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> flush_busy);

    p_clip_x_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> ({1'b0, rect_x} + {1'b0, rect_w} <= {1'b0, scr_w}));

    p_clip_y_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rect_valid |-> ({1'b0, rect_y} + {1'b0, rect_h} <= {1'b0, scr_h}));
endmodule

bind rfe_engine rfe_engine_chk #(.CW(CW)) u_chk (.*);

// File: tb/rfe_engine_tb.sv
module rfe_engine_tb;
    localparam int CW = 12;
    localparam int AW = 24;
    localparam int QD = 8;
    localparam int SW = 16;
    localparam int SH = 8;

    typedef struct packed {
        logic        op;
        logic [2:0]  bpp;
        logic [11:0] sx, sy, dx, dy, w, h;
        logic [31:0] col;
    } vec_t;

    // op, bpp, sx, sy, dx, dy, w, h, colour
    localparam vec_t VECS [7] = '{
        '{1'b0, 3'd3, 12'd0, 12'd0, 12'd1,  12'd1, 12'd5, 12'd3, 32'h00A1B2C3},
        '{1'b0, 3'd4, 12'd0, 12'd0, 12'd12, 12'd6, 12'd6, 12'd4, 32'hDEADBEEF},
        '{1'b1, 3'd2, 12'd0, 12'd0, 12'd2,  12'd2, 12'd6, 12'd4, 32'h0},
        '{1'b1, 3'd2, 12'd3, 12'd3, 12'd1,  12'd1, 12'd6, 12'd4, 32'h0},
        '{1'b1, 3'd1, 12'd0, 12'd4, 12'd3,  12'd4, 12'd8, 12'd2, 32'h0},
        '{1'b1, 3'd1, 12'd5, 12'd5, 12'd2,  12'd5, 12'd8, 12'd1, 32'h0},
        '{1'b0, 3'd1, 12'd0, 12'd0, 12'd20, 12'd2, 12'd3, 12'd2, 32'h00000055}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] scr_w = CW'(SW);
    logic [CW-1:0] scr_h = CW'(SH);
    logic [2:0]    bypp = 3'd1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_op = 1'b0;
    logic [CW-1:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0;
    logic [CW-1:0] cmd_w = '0, cmd_h = '0;
    logic [31:0]   cmd_color = '0;
    logic          done, mem_re, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          flush_req = 1'b0, full_inval = 1'b0;
    logic          flush_busy, rect_valid;
    logic [CW-1:0] rect_x, rect_y, rect_w, rect_h;

    always #4 clk = ~clk;

    rfe_engine #(.CW(CW), .AW(AW), .QDEPTH(QD)) u_dut (.*);

    logic [7:0] mem     [4096];
    logic [7:0] ref_mem [4096];
    int acc_cnt = 0;

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
        if (mem_re || mem_we) acc_cnt <= acc_cnt + 1;
    end

    int n_total = 0;
    int n_fail  = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // reference: snapshot copy, pattern fill, same linear address rule
    task automatic ref_op(input vec_t v);
        logic [7:0] snap [4096];
        int bp, pitch, da, sa;
        bp = int'(v.bpp);
        pitch = bp * SW;
        for (int i = 0; i < 4096; i++) snap[i] = ref_mem[i];
        for (int r = 0; r < int'(v.h); r++) begin
            for (int c = 0; c < int'(v.w) * bp; c++) begin
                da = bp * int'(v.dx) + pitch * (int'(v.dy) + r) + c;
                sa = bp * int'(v.sx) + pitch * (int'(v.sy) + r) + c;
                if (v.op) ref_mem[da] = snap[sa];
                else      ref_mem[da] = 8'(v.col >> (8 * (c % bp)));
            end
        end
    endtask

    task automatic run_op(input vec_t v, input bit discard_at_done, output int cyc);
        @(negedge clk);
        bypp = v.bpp; cmd_op = v.op;
        cmd_sx = v.sx; cmd_sy = v.sy; cmd_dx = v.dx; cmd_dy = v.dy;
        cmd_w = v.w; cmd_h = v.h; cmd_color = v.col;
        chk(cmd_ready == 1'b1, "R6", "ready before command", cmd_ready, 1);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R6", "ready while busy", cmd_ready, 0);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        if (discard_at_done) begin
            flush_req = 1'b1;
            full_inval = 1'b1;
        end
        @(negedge clk);
        flush_req = 1'b0;
        full_inval = 1'b0;
        chk(done == 1'b0, "R6", "done one cycle wide", done, 0);
        chk(cmd_ready == 1'b1, "R6", "ready after done", cmd_ready, 1);
    endtask

    int got_n;
    int got_x [16], got_y [16], got_w [16], got_h [16];

    task automatic drain(input bit inval);
        got_n = 0;
        @(negedge clk);
        flush_req = 1'b1;
        full_inval = inval;
        for (int k = 0; k < 64; k++) begin
            @(negedge clk);
            flush_req = 1'b0;
            full_inval = 1'b0;
            if (rect_valid && got_n < 16) begin
                got_x[got_n] = int'(rect_x); got_y[got_n] = int'(rect_y);
                got_w[got_n] = int'(rect_w); got_h[got_n] = int'(rect_h);
                got_n++;
            end
            if (!flush_busy) break;
        end
    endtask

    function automatic int clip_pos(input int p, input int l, input int lim);
        return (p > lim) ? lim : p;
    endfunction

    function automatic int clip_len(input int p, input int l, input int lim);
        return (p + l > lim) ? lim - clip_pos(p, l, lim) : l;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        int cyc, a0, bad, bp;
        vec_t z;
        for (int i = 0; i < 4096; i++) begin
            mem[i] = 8'(i * 7 + 3);
            ref_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(cmd_ready == 1'b1 && done == 1'b0, "R11", "idle after reset", {cmd_ready, done}, 2);
        chk(!mem_re && !mem_we, "R11", "no access in reset", {mem_re, mem_we}, 0);
        chk(!flush_busy && !rect_valid, "R11", "queue quiet in reset", {flush_busy, rect_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!mem_re && !mem_we && cmd_ready, "R11", "idle out of reset", {mem_re, mem_we, cmd_ready}, 1);

        // stimulus table: R1 R2 R3 R4
        foreach (VECS[i]) begin
            a0 = acc_cnt;
            run_op(VECS[i], 1'b0, cyc);
            ref_op(VECS[i]);
            bp = int'(VECS[i].bpp);
            bad = 0;
            for (int k = 0; k < 1024; k++) if (mem[k] !== ref_mem[k]) bad++;
            chk(bad == 0, VECS[i].op ? "R3" : "R2", "bytes differing from reference", bad, 0);
            chk(acc_cnt - a0 == (VECS[i].op ? 2 : 1) * int'(VECS[i].w) * bp * int'(VECS[i].h),
                VECS[i].op ? "R4" : "R1", "access count", acc_cnt - a0,
                (VECS[i].op ? 2 : 1) * int'(VECS[i].w) * bp * int'(VECS[i].h));
        end

        // R9 R10: drain the seven queued rectangles in order, clipped
        drain(1'b0);
        chk(got_n == 7, "R9", "rectangles drained", got_n, 7);
        for (int i = 0; i < 7 && i < got_n; i++) begin
            chk(got_x[i] == clip_pos(int'(VECS[i].dx), int'(VECS[i].w), SW) &&
                got_w[i] == clip_len(int'(VECS[i].dx), int'(VECS[i].w), SW),
                "R10", "clipped x/w", got_x[i] * 1000 + got_w[i],
                clip_pos(int'(VECS[i].dx), int'(VECS[i].w), SW) * 1000 +
                clip_len(int'(VECS[i].dx), int'(VECS[i].w), SW));
            chk(got_y[i] == clip_pos(int'(VECS[i].dy), int'(VECS[i].h), SH) &&
                got_h[i] == clip_len(int'(VECS[i].dy), int'(VECS[i].h), SH),
                "R10", "clipped y/h", got_y[i] * 1000 + got_h[i],
                clip_pos(int'(VECS[i].dy), int'(VECS[i].h), SH) * 1000 +
                clip_len(int'(VECS[i].dy), int'(VECS[i].h), SH));
        end

        // R5 R7: QD zero-sized commands, no access, queue wraps to empty
        z = '{1'b0, 3'd2, 12'd0, 12'd0, 12'd0, 12'd1, 12'd0, 12'd2, 32'h0};
        a0 = acc_cnt;
        for (int i = 0; i < QD; i++) begin
            z.dx = 12'(i);
            run_op(z, 1'b0, cyc);
            chk(cyc <= 1, "R5", "zero-size completion cycles", cyc, 1);
        end
        chk(acc_cnt == a0, "R5", "accesses for zero-size", acc_cnt - a0, 0);
        drain(1'b0);
        chk(got_n == 0, "R7", "rectangles after wrap", got_n, 0);

        // R9: three entries come out oldest first
        for (int i = 0; i < 3; i++) begin
            z.dx = 12'(3 + i);
            run_op(z, 1'b0, cyc);
        end
        drain(1'b0);
        chk(got_n == 3, "R9", "count of three", got_n, 3);
        chk(got_n == 3 && got_x[0] == 3 && got_x[1] == 4 && got_x[2] == 5, "R9",
            "order of x", got_x[0] * 100 + got_x[1] * 10 + got_x[2], 345);

        // R8: discard coinciding with a push keeps only the new entry
        z.dx = 12'd7;  run_op(z, 1'b0, cyc);
        z.dx = 12'd8;  run_op(z, 1'b0, cyc);
        z.dx = 12'd9;  run_op(z, 1'b1, cyc);
        drain(1'b0);
        chk(got_n == 1, "R8", "entries surviving discard", got_n, 1);
        chk(got_n == 1 && got_x[0] == 9, "R8", "surviving entry x", got_x[0], 9);

        // R8: plain discard yields nothing, then nothing remains
        z.dx = 12'd2;  run_op(z, 1'b0, cyc);
        drain(1'b1);
        chk(got_n == 0 && flush_busy == 1'b0, "R8", "discard output", got_n, 0);
        drain(1'b0);
        chk(got_n == 0, "R8", "queue empty after discard", got_n, 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule